// File: doc/BRIEF.md
# Carry-Split Pipelined Phase Accumulator

This block is a numerically controlled phase accumulator. Each clock it adds an increment word to a running phase, and the phase wraps modulo two to the width. The top bit of the phase is a square wave whose frequency is proportional to the increment. The accumulator is meant for clock rates at which a single full-width carry chain in a feedback loop would be too slow.

To shorten that path, the accumulator is cut into a lower and an upper section. The carry out of the lower section is caught in a flip-flop and added into the upper section one clock later. The upper increment bits get a one-cycle delay register. The lower sum also passes through a one-cycle delay register before it is joined to the upper sum. With these delays the assembled output is always a coherent phase word, exactly one clock behind an ideal unsplit accumulator. The increment may change on any clock.

Top module: `phase_acc_split`

## Requirements
- R1: During synchronous active-low reset, all section registers, the carry register and both delay registers clear to zero. The phase output reads zero in the first cycle after reset is released.
- R2: For any increment sequence, `phase` after clock edge n equals the sum of all increments applied at edges 1 to n-1 since reset, modulo 2^WIDTH. This is a plain accumulator delayed by exactly one clock. With increment 3 held, the outputs after release are 0, 3, 6.
- R3: The carry out of the lower section is registered and added into the upper section on the next clock, so sums that cross the section boundary come out correct.
- R4: The upper increment bits reach the upper section through a one-cycle delay. The increment may change on every clock and no output word is ever corrupted.
- R5: The lower section sum is delayed one cycle before it reaches bits LO_W-1..0 of `phase`. The lower section's own feedback is not delayed.
- R6: `sq_out` always equals bit WIDTH-1 of `phase`.
- R7: The phase wraps modulo 2^WIDTH. An all-ones increment makes the phase count down by one each clock.
- R8: Asserting `rst_n` low in the middle of a run returns the phase to zero at the next clock edge, and accumulation restarts from zero.
- R9: WIDTH is a parameter. The lower section is WIDTH/2 bits wide and the upper section takes the rest. Every increment of an 8-bit instance gives the same delayed-accumulator behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| incr | input | WIDTH | Phase increment (tuning word) |
| phase | output | WIDTH | Accumulated phase, one clock behind an unsplit accumulator |
| sq_out | output | 1 | Square wave, the phase MSB |

## Verification
Several properties are checked on every cycle. The checker confirms that the registered carry matches the previous lower-section overflow, and that the upper increment and the lower sum each arrive exactly one clock late. It also checks that the upper phase advances by the delayed increment plus the carry, that the square output tracks the MSB, and that the output is zero right after reset. Whole-word behaviour can only be shown by the bench's scenarios: equivalence with an unsplit accumulator over long runs, increments that change every clock, wrap-around, reset in mid-run, and an exhaustive sweep of increments on an 8-bit instance.

// File: rtl/phase_split_pkg.sv
// Package: shared sizing helpers for the carry-split phase accumulator.
// Assumes: widths are at least 2 bits so that both sections are non-empty.
package phase_split_pkg;

    // Width of the lower (carry-producing) section for a given total width.
    function automatic int lo_width(input int total);
        return total / 2;
    endfunction

    // Width of the upper (carry-consuming) section for a given total width.
    function automatic int hi_width(input int total);
        return total - (total / 2);
    endfunction

endpackage

// File: rtl/seg_acc_lo.sv
// Module: lower accumulator section.
// Adds its addend to its own value every clock with undelayed feedback, and
// registers the carry out of that addition for the section above.
// Assumes: synchronous active-low reset clears the sum and the carry.
module seg_acc_lo #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] addend,
    output logic [W-1:0] acc,
    output logic         carry_q
);

    logic [W:0] wide_sum;

    // Full sum including the carry bit out of the section.
    always_comb begin
        wide_sum = {1'b0, acc} + {1'b0, addend};
    end

    // Accumulate and capture the outgoing carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            carry_q <= 1'b0;
        end else begin
            acc     <= wide_sum[W-1:0];
            carry_q <= wide_sum[W];
        end
    end

endmodule

// File: rtl/seg_acc_hi.sv
// Module: upper accumulator section.
// Adds a (pre-delayed) addend and a registered carry-in to its own value
// every clock; the overflow of this top section is discarded (modulo wrap).
// Assumes: addend and cin already lag the lower section by one clock.
module seg_acc_hi #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] addend,
    input  logic         cin,
    output logic [W-1:0] acc
);

    logic [W-1:0] cin_ext;

    // Zero-extend the carry to the section width.
    always_comb begin
        cin_ext = {{(W-1){1'b0}}, cin};
    end

    // Accumulate modulo 2^W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            acc <= acc + addend + cin_ext;
        end
    end

endmodule

// File: rtl/pipe_reg.sv
// Module: one-cycle alignment register.
// Delays a word by one clock; used to skew the upper increment and the lower sum.
// Assumes: synchronous active-low reset clears it.
module pipe_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Single-stage delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/phase_acc_split.sv
// Module: carry-split pipelined phase accumulator (top).
// The phase is split into a lower and an upper section with a registered
// carry between them. The upper increment and the lower sum are each delayed
// one clock so that the output word is coherent and exactly one clock behind
// an unsplit accumulator.
// Assumes: WIDTH >= 2; incr may change on any clock.
module phase_acc_split
    import phase_split_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] incr,
    output logic [WIDTH-1:0] phase,
    output logic             sq_out
);

    localparam int LO_W = lo_width(WIDTH);
    localparam int HI_W = hi_width(WIDTH);

    logic [LO_W-1:0] lo_acc;
    logic            lo_carry_q;
    logic [HI_W-1:0] inc_hi_q;
    logic [HI_W-1:0] hi_acc;
    logic [LO_W-1:0] lo_phase_q;

    // Lower section: undelayed feedback, registered carry out.
    seg_acc_lo #(.W(LO_W)) u_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .addend  (incr[LO_W-1:0]),
        .acc     (lo_acc),
        .carry_q (lo_carry_q)
    );

    // Skew the upper increment bits by one clock.
    pipe_reg #(.W(HI_W)) u_inc_skew (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (incr[WIDTH-1:LO_W]),
        .q     (inc_hi_q)
    );

    // Upper section consumes the delayed increment and the registered carry.
    seg_acc_hi #(.W(HI_W)) u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .addend (inc_hi_q),
        .cin    (lo_carry_q),
        .acc    (hi_acc)
    );

    // Align the lower sum with the upper sum on the output.
    pipe_reg #(.W(LO_W)) u_lo_align (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lo_acc),
        .q     (lo_phase_q)
    );

    // Assemble the output word and the square wave.
    always_comb begin
        phase  = {hi_acc, lo_phase_q};
        sq_out = hi_acc[HI_W-1];
    end

endmodule

// File: rtl/phase_acc_split_chk.sv
// Module: assertion checker for phase_acc_split, attached with bind.
// Assumes: it observes the internal section and delay signals through bind.
module phase_acc_split_chk #(
    parameter int WIDTH = 32,
    parameter int LO_W  = 16,
    parameter int HI_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] incr,
    input logic [WIDTH-1:0] phase,
    input logic             sq_out,
    input logic [LO_W-1:0]  lo_acc,
    input logic             lo_carry_q,
    input logic [HI_W-1:0]  inc_hi_q,
    input logic [HI_W-1:0]  hi_acc
);

    logic            rst_d;
    logic [LO_W:0]   lo_wide;
    logic [HI_W-1:0] hi_next;

    // Remember whether the previous sample was out of reset.
    always_ff @(posedge clk) begin
        rst_d <= rst_n;
    end

    // Expected carry and upper step, formed from observed signals.
    always_comb begin
        lo_wide = {1'b0, lo_acc} + {1'b0, incr[LO_W-1:0]};
        hi_next = hi_acc + inc_hi_q + {{(HI_W-1){1'b0}}, lo_carry_q};
    end

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_d |-> phase == '0);

    p_carry_hand_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_d |-> lo_carry_q == $past(lo_wide[LO_W]));

    p_inc_skew_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_d |-> inc_hi_q == $past(incr[WIDTH-1:LO_W]));

    p_low_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_d |-> phase[LO_W-1:0] == $past(lo_acc));

    p_square_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sq_out == phase[WIDTH-1]);

    p_hi_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_d |-> phase[WIDTH-1:LO_W] == $past(hi_next));

endmodule

bind phase_acc_split phase_acc_split_chk #(
    .WIDTH (WIDTH),
    .LO_W  (LO_W),
    .HI_W  (HI_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .incr       (incr),
    .phase      (phase),
    .sq_out     (sq_out),
    .lo_acc     (lo_acc),
    .lo_carry_q (lo_carry_q),
    .inc_hi_q   (inc_hi_q),
    .hi_acc     (hi_acc)
);

// File: tb/test_phase_acc_split.sv
// Bench: drives a 32-bit and an 8-bit instance and compares each against an
// unsplit accumulator model delayed one clock. Inputs change at negedge and
// outputs are sampled at negedge.
module test_phase_acc_split;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] inc32 = '0;
    logic [7:0]  inc8 = '0;
    logic [31:0] phase32;
    logic [7:0]  phase8;
    logic        sq32;
    logic        sq8;

    logic [31:0] m32;
    logic [31:0] o32;
    logic [7:0]  m8;
    logic [7:0]  o8;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    phase_acc_split #(.WIDTH(32)) i_phase_acc_split (
        .clk(clk), .rst_n(rst_n), .incr(inc32), .phase(phase32), .sq_out(sq32)
    );

    phase_acc_split #(.WIDTH(8)) i_phase_acc_split_w8 (
        .clk(clk), .rst_n(rst_n), .incr(inc8), .phase(phase8), .sq_out(sq8)
    );

    // Reference: unsplit accumulator, its value shown one clock later.
    always @(posedge clk) begin
        if (!rst_n) begin
            m32 <= '0; o32 <= '0; m8 <= '0; o8 <= '0;
        end else begin
            m32 <= m32 + inc32; o32 <= m32;
            m8  <= m8 + inc8;   o8  <= m8;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Compare both instances with the model.
    task automatic cmp_all(input string req);
        chk(req, phase32, o32);
        chk({req, "/R6"}, {31'b0, sq32}, {31'b0, o32[31]});
        chk({req, "/w8"}, {24'b0, phase8}, {24'b0, o8});
    endtask

    task automatic run32(input logic [31:0] v, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            inc32 = v;
            tick();
            cmp_all(req);
        end
    endtask

    initial begin
        logic [31:0] lfsr;
        repeat (3) tick();
        // R1: outputs zero during reset
        chk("R1", phase32, 32'h0);
        chk("R1", {31'b0, sq32}, 32'h0);
        chk("R1", {24'b0, phase8}, 32'h0);

        // R2: literal one-clock latency with increment 3
        inc32 = 32'd3;
        rst_n = 1'b1;
        tick(); chk("R2", phase32, 32'd0);
        tick(); chk("R2", phase32, 32'd3);
        tick(); chk("R2", phase32, 32'd6);
        run32(32'd3, 5, "R2");

        // R3: lower half overflows often, upper must absorb carries
        run32(32'h0000_8000, 12, "R3");
        run32(32'h0000_FFFF, 12, "R3");
        run32(32'h0001_0000, 6, "R3");

        // R7: all-ones increment counts down and wraps
        run32(32'hFFFF_FFFF, 12, "R7");

        // R6: large step toggles the square wave
        run32(32'h7FFF_FFFF, 10, "R6");

        // R4: increment changes on every clock
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            inc32 = lfsr;
            inc8  = lfsr[15:8];
            tick();
            cmp_all("R4");
        end

        // R8: reset in the middle of a run
        rst_n = 1'b0;
        tick();
        chk("R8", phase32, 32'h0);
        chk("R8", {24'b0, phase8}, 32'h0);
        rst_n = 1'b1;
        inc32 = 32'h1234_5678;
        tick(); chk("R8", phase32, 32'h0);
        tick(); chk("R8", phase32, 32'h1234_5678);

        // R9: exhaustive sweep of 8-bit increments, two clocks each
        for (int v = 0; v < 256; v++) begin
            inc8  = v[7:0];
            inc32 = {v[7:0], v[7:0], v[7:0], v[7:0]};
            tick(); cmp_all("R9");
            tick(); cmp_all("R9");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule